// File: doc/BRIEF.md
# Network Mailbox Target Port

This block sits between an on-chip message network and the devices of one tile. Every incoming network word carries three fields: an object identifier, an operation code and a data payload. The object identifier is looked up in a host-writable group table that returns a target-enable mask, so one identifier can address a single device or several at once (for example the RAM bank, the arithmetic bank and the fine-grain logic). The operation code indexes a second host-writable table whose entry is driven onto the tile's control points for exactly one cycle, alongside the data word, to every enabled target.

Words arrive either as stand-alone messages or as packets of unknown length framed by a two-bit mark field. The word that opens a packet fixes the destination set for the whole packet; the local automata in the targets see first-word and last-word flags and so can process messages whose length is not known in advance. Framing violations are dropped and reported on a one-cycle error pulse. All outputs are registered: a word presented in one cycle appears at the targets in the next.

Top module: `mbox_target_port`

## Requirements
- R1: After reset all target enables, control bits, frame flags, the error flag and the packet-open flag are 0, and both tables hold 0, so a word sent before any table write enables no target and drives control value 0.
- R2: A word with mark 2'b00 while no packet is open is a single-word message: one cycle after it is presented, `tgt_en` equals the group-table mask of its object identifier, `tgt_data` equals its data, and `tgt_first`/`tgt_last` are 0.
- R3: A group-table write (`grp_we`) stores a 4-bit mask at an 8-bit object identifier; it affects words presented in later cycles, while a word presented in the same cycle as the write uses the previous mask.
- R4: For every accepted word `tgt_ctrl` equals the signal-table entry (16 entries of 8 bits, written with `sig_we`) selected by its 4-bit opcode for exactly one cycle; in every other cycle `tgt_ctrl` is 0.
- R5: A word with mark 2'b01 (start) while no packet is open is delivered with `tgt_first`=1, opens a packet (`pkt_open`=1) and fixes the packet's destination mask to the group-table mask of its object identifier.
- R6: A word with mark 2'b00 inside an open packet is delivered to the packet's fixed mask; its own object identifier is ignored.
- R7: A word with mark 2'b10 (stop) inside an open packet is delivered to the packet's fixed mask with `tgt_last`=1 and closes the packet.
- R8: A stop word while no packet is open is dropped (no target enable, control 0) and `proto_err` is 1 in the following cycle.
- R9: A start word while a packet is open is dropped with `proto_err`; the packet stays open with its original mask.
- R10: A word with mark 2'b11 while no packet is open is a one-word packet delivered to its own group mask with both `tgt_first` and `tgt_last` set, leaving no packet open; while a packet is open it is dropped with `proto_err`.
- R11: In a cycle where `in_valid` is 0, the next cycle shows no target enable, control 0 and no error, and packet state is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Network word present this cycle |
| in_obj | input | 8 | Object identifier of the word |
| in_opc | input | 4 | Operation code of the word |
| in_mark | input | 2 | Frame mark: 00 none, 01 start, 10 stop, 11 start and stop |
| in_data | input | 32 | Data payload |
| grp_we | input | 1 | Group-table write strobe |
| grp_addr | input | 8 | Object identifier to write |
| grp_mask | input | 4 | Target-enable mask to store |
| sig_we | input | 1 | Signal-table write strobe |
| sig_addr | input | 4 | Opcode entry to write |
| sig_val | input | 8 | Control-point value to store |
| tgt_en | output | 4 | Per-target enable, one cycle per delivered word |
| tgt_data | output | 32 | Data delivered to the enabled targets |
| tgt_ctrl | output | 8 | Control-point value for the delivered word |
| tgt_first | output | 1 | Delivered word opens a packet |
| tgt_last | output | 1 | Delivered word closes a packet |
| pkt_open | output | 1 | A packet is currently open |
| proto_err | output | 1 | Previous-cycle word was dropped for a framing violation |

## Verification
The host write path and the network lookup path can touch the same group-table entry in one cycle. The bench provokes this by raising `grp_we` for an identifier in the same cycle that a word with that identifier is presented, and judges that the delivered enable carries the old mask while the next word to that identifier carries the new one. A second collision, a start mark arriving inside an open packet, is judged by checking that the error pulse appears, nothing is delivered, and the following continuation word still reaches the mask fixed by the first start.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned OBJ_W  = 8;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TGT_N  = 4;
  localparam int unsigned CTRL_W = 8;

  typedef enum logic [1:0] {
    MK_NONE  = 2'b00,
    MK_START = 2'b01,
    MK_STOP  = 2'b10,
    MK_BOTH  = 2'b11
  } mark_e;
endpackage

// File: rtl/mbox_lut.sv
// Host-written lookup table with a combinational read port.
// A write becomes visible to the read port from the next cycle.
module mbox_lut #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DAT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DAT_W-1:0]  rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DAT_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[i] <= '0;
      else if (hit) mem_q[i] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/mbox_frame_ctl.sv
// Packet framing state: decides acceptance, error and mask source per word.
module mbox_frame_ctl
  import mbox_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  word_vld,
  input  mark_e mark,
  output logic  accept,
  output logic  drop_err,
  output logic  latch_mask,
  output logic  use_latched,
  output logic  is_first,
  output logic  is_last,
  output logic  open_o
);
  logic open_q, open_d;

  always_comb begin
    accept      = 1'b0;
    drop_err    = 1'b0;
    latch_mask  = 1'b0;
    use_latched = 1'b0;
    is_first    = 1'b0;
    is_last     = 1'b0;
    open_d      = open_q;
    if (word_vld) begin
      unique case (mark)
        MK_NONE: begin
          accept      = 1'b1;
          use_latched = open_q;
        end
        MK_START: begin
          if (open_q) drop_err = 1'b1;
          else begin
            accept     = 1'b1;
            latch_mask = 1'b1;
            is_first   = 1'b1;
            open_d     = 1'b1;
          end
        end
        MK_STOP: begin
          if (!open_q) drop_err = 1'b1;
          else begin
            accept      = 1'b1;
            use_latched = 1'b1;
            is_last     = 1'b1;
            open_d      = 1'b0;
          end
        end
        MK_BOTH: begin
          if (open_q) drop_err = 1'b1;
          else begin
            accept   = 1'b1;
            is_first = 1'b1;
            is_last  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign open_o = open_q;
endmodule

// File: rtl/mbox_target_port.sv
module mbox_target_port
  import mbox_pkg::*;
#(
  parameter int unsigned OBJ_BITS  = OBJ_W,
  parameter int unsigned OPC_BITS  = OPC_W,
  parameter int unsigned DATA_BITS = DATA_W,
  parameter int unsigned TGT_CNT   = TGT_N,
  parameter int unsigned CTRL_BITS = CTRL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [OBJ_BITS-1:0]  in_obj,
  input  logic [OPC_BITS-1:0]  in_opc,
  input  logic [1:0]           in_mark,
  input  logic [DATA_BITS-1:0] in_data,
  input  logic                 grp_we,
  input  logic [OBJ_BITS-1:0]  grp_addr,
  input  logic [TGT_CNT-1:0]   grp_mask,
  input  logic                 sig_we,
  input  logic [OPC_BITS-1:0]  sig_addr,
  input  logic [CTRL_BITS-1:0] sig_val,
  output logic [TGT_CNT-1:0]   tgt_en,
  output logic [DATA_BITS-1:0] tgt_data,
  output logic [CTRL_BITS-1:0] tgt_ctrl,
  output logic                 tgt_first,
  output logic                 tgt_last,
  output logic                 pkt_open,
  output logic                 proto_err
);
  logic [TGT_CNT-1:0]   look_mask;
  logic [CTRL_BITS-1:0] look_ctrl;
  logic accept, drop_err, latch_mask, use_latched, is_first, is_last;

  mbox_lut #(.ADDR_W(OBJ_BITS), .DAT_W(TGT_CNT)) u_grp_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(grp_we), .wr_addr(grp_addr), .wr_data(grp_mask),
    .rd_addr(in_obj), .rd_data(look_mask)
  );

  mbox_lut #(.ADDR_W(OPC_BITS), .DAT_W(CTRL_BITS)) u_sig_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sig_we), .wr_addr(sig_addr), .wr_data(sig_val),
    .rd_addr(in_opc), .rd_data(look_ctrl)
  );

  mbox_frame_ctl u_frame (
    .clk(clk), .rst_n(rst_n),
    .word_vld(in_valid), .mark(mark_e'(in_mark)),
    .accept(accept), .drop_err(drop_err),
    .latch_mask(latch_mask), .use_latched(use_latched),
    .is_first(is_first), .is_last(is_last), .open_o(pkt_open)
  );

  // Destination mask fixed by the packet's start word.
  logic [TGT_CNT-1:0] pkt_mask_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pkt_mask_q <= '0;
    else if (latch_mask) pkt_mask_q <= look_mask;
  end

  // Output stage: next-state logic.
  logic [TGT_CNT-1:0]   en_d;
  logic [CTRL_BITS-1:0] ctrl_d;
  logic                 first_d, last_d;
  always_comb begin
    en_d    = '0;
    ctrl_d  = '0;
    first_d = 1'b0;
    last_d  = 1'b0;
    if (accept) begin
      en_d    = use_latched ? pkt_mask_q : look_mask;
      ctrl_d  = look_ctrl;
      first_d = is_first;
      last_d  = is_last;
    end
  end

  // Output stage: registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_en    <= '0;
      tgt_ctrl  <= '0;
      tgt_first <= 1'b0;
      tgt_last  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      tgt_en    <= en_d;
      tgt_ctrl  <= ctrl_d;
      tgt_first <= first_d;
      tgt_last  <= last_d;
      proto_err <= drop_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_data <= '0;
    else if (accept) tgt_data <= in_data;
  end
endmodule

// File: rtl/mbox_target_port_chk.sv
module mbox_target_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] in_mark,
  input logic [3:0] tgt_en,
  input logic [7:0] tgt_ctrl,
  input logic       tgt_first,
  input logic       tgt_last,
  input logic       pkt_open,
  input logic       proto_err
);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (tgt_en == '0) && (tgt_ctrl == '0) && !proto_err);

  p_idle_keeps_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pkt_open));

  p_err_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (tgt_en == '0) && (tgt_ctrl == '0) && !tgt_first && !tgt_last);

  p_orphan_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mark == 2'b10 && !pkt_open) |=> proto_err && !pkt_open);

  p_start_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mark == 2'b01 && !pkt_open) |=> pkt_open && tgt_first);

  p_stop_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mark == 2'b10 && pkt_open) |=> !pkt_open && tgt_last);

  p_restart_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mark == 2'b01 && pkt_open) |=> pkt_open && proto_err);

  p_oneword_pkt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mark == 2'b11 && !pkt_open) |=> tgt_first && tgt_last && !pkt_open);
endmodule

bind mbox_target_port mbox_target_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mark(in_mark),
  .tgt_en(tgt_en), .tgt_ctrl(tgt_ctrl), .tgt_first(tgt_first),
  .tgt_last(tgt_last), .pkt_open(pkt_open), .proto_err(proto_err)
);

// File: tb/mbox_target_port_tb.sv
`timescale 1ns/1ps
module mbox_target_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_obj = '0;
  logic [3:0]  in_opc = '0;
  logic [1:0]  in_mark = '0;
  logic [31:0] in_data = '0;
  logic        grp_we = 1'b0;
  logic [7:0]  grp_addr = '0;
  logic [3:0]  grp_mask = '0;
  logic        sig_we = 1'b0;
  logic [3:0]  sig_addr = '0;
  logic [7:0]  sig_val = '0;
  logic [3:0]  tgt_en;
  logic [31:0] tgt_data;
  logic [7:0]  tgt_ctrl;
  logic        tgt_first, tgt_last, pkt_open, proto_err;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  mbox_target_port u_dut (.*);

  function automatic logic [7:0] sig_of(input logic [3:0] op);
    return {op, ~op};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one word for one cycle; on return the registered result is visible.
  task automatic send(input logic [7:0] obj, input logic [3:0] op,
                      input logic [1:0] mk, input logic [31:0] d);
    in_valid = 1'b1; in_obj = obj; in_opc = op; in_mark = mk; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr_grp(input logic [7:0] a, input logic [3:0] m);
    grp_we = 1'b1; grp_addr = a; grp_mask = m;
    @(negedge clk);
    grp_we = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [3:0] en, input logic [31:0] d,
                             input logic [3:0] op, input logic f, input logic l);
    check(req, {60'd0, tgt_en}, {60'd0, en});
    check(req, {32'd0, tgt_data}, {32'd0, d});
    check(req, {56'd0, tgt_ctrl}, {56'd0, sig_of(op)});
    check(req, {62'd0, tgt_first, tgt_last}, {62'd0, f, l});
  endtask

  task automatic t_reset;
    check("R1 en", {60'd0, tgt_en}, 64'd0);
    check("R1 ctrl", {56'd0, tgt_ctrl}, 64'd0);
    check("R1 flags", {60'd0, tgt_first, tgt_last, pkt_open, proto_err}, 64'd0);
    send(8'd1, 4'd3, 2'b00, 32'h1111);
    check("R1 empty tables en", {60'd0, tgt_en}, 64'd0);
    check("R1 empty tables ctrl", {56'd0, tgt_ctrl}, 64'd0);
    @(negedge clk);
  endtask

  task automatic t_program;
    for (int i = 0; i < 16; i++) begin
      sig_we = 1'b1; sig_addr = 4'(i); sig_val = sig_of(4'(i));
      @(negedge clk);
    end
    sig_we = 1'b0;
    wr_grp(8'd1, 4'b0001);
    wr_grp(8'd2, 4'b0010);
    wr_grp(8'd3, 4'b1100);
    wr_grp(8'd7, 4'b1111);
  endtask

  task automatic t_single;
    send(8'd1, 4'd3, 2'b00, 32'hA5A5_0001);
    expect_word("R2 R4 single obj1", 4'b0001, 32'hA5A5_0001, 4'd3, 1'b0, 1'b0);
    @(negedge clk);
    check("R4 one cycle en", {60'd0, tgt_en}, 64'd0);
    check("R4 one cycle ctrl", {56'd0, tgt_ctrl}, 64'd0);
    send(8'd7, 4'd15, 2'b00, 32'hDEAD_BEEF);
    expect_word("R2 group obj7", 4'b1111, 32'hDEAD_BEEF, 4'd15, 1'b0, 1'b0);
    send(8'd3, 4'd0, 2'b00, 32'h0000_0033);
    expect_word("R2 R4 back-to-back obj3", 4'b1100, 32'h33, 4'd0, 1'b0, 1'b0);
    send(8'd9, 4'd5, 2'b00, 32'h99);
    expect_word("R4 zero-mask word still drives ctrl", 4'b0000, 32'h99, 4'd5, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_idle;
    in_obj = 8'd7; in_mark = 2'b10; in_opc = 4'd2;
    @(negedge clk);
    @(negedge clk);
    check("R11 idle en", {60'd0, tgt_en}, 64'd0);
    check("R11 idle ctrl/err", {55'd0, tgt_ctrl, proto_err}, 64'd0);
    check("R11 idle pkt_open", {63'd0, pkt_open}, 64'd0);
  endtask

  task automatic t_packet;
    send(8'd3, 4'd1, 2'b01, 32'h100);
    expect_word("R5 start", 4'b1100, 32'h100, 4'd1, 1'b1, 1'b0);
    check("R5 open", {63'd0, pkt_open}, 64'd1);
    send(8'd1, 4'd2, 2'b00, 32'h101);
    expect_word("R6 continuation uses fixed mask", 4'b1100, 32'h101, 4'd2, 1'b0, 1'b0);
    send(8'd2, 4'd4, 2'b01, 32'h102);
    check("R9 restart err", {63'd0, proto_err}, 64'd1);
    check("R9 restart dropped en", {60'd0, tgt_en}, 64'd0);
    check("R9 restart dropped ctrl", {56'd0, tgt_ctrl}, 64'd0);
    check("R9 still open", {63'd0, pkt_open}, 64'd1);
    send(8'd7, 4'd6, 2'b00, 32'h103);
    expect_word("R9 mask kept", 4'b1100, 32'h103, 4'd6, 1'b0, 1'b0);
    check("R9 err single", {63'd0, proto_err}, 64'd0);
    send(8'd2, 4'd7, 2'b10, 32'h104);
    expect_word("R7 stop", 4'b1100, 32'h104, 4'd7, 1'b0, 1'b1);
    check("R7 closed", {63'd0, pkt_open}, 64'd0);
    send(8'd2, 4'd8, 2'b00, 32'h105);
    expect_word("R2 after close uses own obj", 4'b0010, 32'h105, 4'd8, 1'b0, 1'b0);
  endtask

  task automatic t_orphan;
    send(8'd1, 4'd9, 2'b10, 32'h200);
    check("R8 err", {63'd0, proto_err}, 64'd1);
    check("R8 dropped en", {60'd0, tgt_en}, 64'd0);
    check("R8 dropped ctrl", {56'd0, tgt_ctrl}, 64'd0);
    check("R8 no last", {63'd0, tgt_last}, 64'd0);
    @(negedge clk);
    check("R8 err clears", {63'd0, proto_err}, 64'd0);
  endtask

  task automatic t_both;
    send(8'd2, 4'd10, 2'b11, 32'h300);
    expect_word("R10 one-word packet", 4'b0010, 32'h300, 4'd10, 1'b1, 1'b1);
    check("R10 stays closed", {63'd0, pkt_open}, 64'd0);
    send(8'd1, 4'd11, 2'b01, 32'h301);
    expect_word("R5 start obj1", 4'b0001, 32'h301, 4'd11, 1'b1, 1'b0);
    send(8'd7, 4'd12, 2'b11, 32'h302);
    check("R10 inside packet err", {63'd0, proto_err}, 64'd1);
    check("R10 inside packet dropped", {60'd0, tgt_en}, 64'd0);
    check("R10 packet still open", {63'd0, pkt_open}, 64'd1);
    send(8'd7, 4'd13, 2'b10, 32'h303);
    expect_word("R7 stop after both", 4'b0001, 32'h303, 4'd13, 1'b0, 1'b1);
  endtask

  task automatic t_collide;
    grp_we = 1'b1; grp_addr = 8'd2; grp_mask = 4'b0101;
    in_valid = 1'b1; in_obj = 8'd2; in_opc = 4'd14; in_mark = 2'b00; in_data = 32'h400;
    @(negedge clk);
    grp_we = 1'b0; in_valid = 1'b0;
    expect_word("R3 same-cycle write uses old mask", 4'b0010, 32'h400, 4'd14, 1'b0, 1'b0);
    send(8'd2, 4'd14, 2'b00, 32'h401);
    expect_word("R3 new mask next word", 4'b0101, 32'h401, 4'd14, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_program;
    t_single;
    t_idle;
    t_packet;
    t_orphan;
    t_both;
    t_collide;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule